// File: doc/BRIEF.md
# Load/store queue ordering checker

This block keeps track of memory operations that have been dispatched but not yet executed. It holds them in two small queues, one for loads and one for stores, and says for any tagged operation whether it may issue now under a weak ordering model. Each operation arrives in program order with a tag and three attribute bits: reads memory, writes memory, and has side effects. An operation that reads takes a load-queue slot. One that writes takes a store-queue slot. One that does both takes one slot in each. An operation with side effects acts as a barrier for the queue or queues it sits in.

The pipeline offers operations on an allocation port, and that port is held off when a needed queue has no room. The scheduler asks about one tag at a time on a query port and gets a ready bit back in the same cycle. When an operation completes, its tag is given on the executed port, and every slot held by that tag is released. Operations may complete in any order. Full and empty flags are reported for each queue. Each queue has a configured size: a nonzero size caps its occupancy, and a size of zero leaves only the physical depth as the limit.

Top module: `lsq_order_checker`

## Requirements
- R1: The read bit alone takes one load-queue slot and the write bit alone takes one store-queue slot. Both bits set take one slot in each queue. With neither bit set, an accepted operation takes no slot, both empty flags are unchanged, and a query of its tag returns 0.
- R2: A store-queue operation is not ready while any older store-queue operation is still held.
- R3: A store-queue operation is not ready while any older load-queue operation is still held. This holds whatever the level of `no_alias_i`.
- R4: A load may be ready while older loads are still held, provided no older load barrier is held and no older store blocks it.
- R5: A load is not ready while an older store is held and `no_alias_i` is 0. When `no_alias_i` is 1, older stores never block a load.
- R6: An operation with the read and side-effect bits set is a load barrier. A younger load is not ready while the barrier is held. The barrier itself becomes ready only when no older load-queue operation is held.
- R7: An operation with the write and side-effect bits set is a store barrier, and it is ready only when it is the oldest store-queue operation. An operation with read, write and side-effect bits set is a full barrier: it blocks both younger loads and younger stores, and it waits until it is the oldest entry in both queues.
- R8: `lq_full_o` is 1 exactly when the load queue holds LQ_SIZE entries (default 3). With SQ_SIZE = 0 (the default), `sq_full_o` stays 0 even when all SQ_DEPTH (4) physical slots are in use.
- R9: `alloc_ready_o` is 0 when the offered operation needs a queue that is full or whose physical slots are all in use. A refused operation leaves no state behind. An operation that does not need the blocked queue is still accepted.
- R10: The executed port releases every slot held by the given tag, in any order relative to allocation. A tag that is not held changes nothing.
- R11: `query_ready_o` follows the queried tag and the current queue contents in the same cycle, with no clock delay. A tag that is not held reads 0.
- R12: When an allocation and an execution occur in the same cycle, both take effect. Room for the allocation is judged on the occupancy before that edge.
- R13: After reset both queues are empty, neither full flag is set, and any offered operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| no_alias_i | input | 1 | 1: loads never wait for older stores |
| alloc_valid_i | input | 1 | An operation is offered for allocation |
| alloc_ready_o | output | 1 | The offered operation can be accepted |
| alloc_tag_i | input | TAG_W | Tag of the offered operation |
| alloc_ld_i | input | 1 | Offered operation reads memory |
| alloc_st_i | input | 1 | Offered operation writes memory |
| alloc_se_i | input | 1 | Offered operation has side effects (barrier) |
| query_tag_i | input | TAG_W | Tag whose issue readiness is asked |
| query_ready_o | output | 1 | Queried tag may issue now |
| exec_valid_i | input | 1 | An operation has executed |
| exec_tag_i | input | TAG_W | Tag of the executed operation |
| lq_full_o | output | 1 | Load queue at configured size |
| lq_empty_o | output | 1 | Load queue holds nothing |
| sq_full_o | output | 1 | Store queue at configured size |
| sq_empty_o | output | 1 | Store queue holds nothing |

## Verification
The hardest case to reach from the ports is a full barrier that sits between entries in both queues, with older and younger operations completing out of order, so that its age links into each queue must be cleared one at a time. The stimulus builds this directly: it places a load ahead of a full barrier and a load and a store behind it, then executes them one by one while the answers to the barrier and to its younger operations are read back after each release. A second case that is hard to reach is an allocation and a release in the same cycle while the load queue is close to its limit. It is brought about by filling the load queue to one below its size and then pairing an execute with an allocate on one edge.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Load side of the issue rule: older load barrier, older store (alias mode),
  // and for a barrier itself, any older load.
  function automatic logic load_side_ok(input logic older_ld_bar,
                                        input logic older_st,
                                        input logic older_ld,
                                        input logic is_bar,
                                        input logic no_alias);
    return !older_ld_bar && (no_alias || !older_st) && (!is_bar || !older_ld);
  endfunction

  // Store side of the issue rule: every older store or load holds it back.
  function automatic logic store_side_ok(input logic older_st,
                                         input logic older_ld,
                                         input logic older_st_bar,
                                         input logic is_bar);
    return !older_st && !older_ld && !older_st_bar && (!is_bar || !older_st);
  endfunction

  // Room check: configured size (0 = unlimited) and physical slots.
  function automatic logic queue_blocked(input int count,
                                         input int cfg_size,
                                         input logic slot_avail);
    return ((cfg_size != 0) && (count >= cfg_size)) || !slot_avail;
  endfunction

endpackage

// File: rtl/lsq_queue.sv
module lsq_queue #(
  parameter int DEPTH       = 4,
  parameter int OTHER_DEPTH = 4,
  parameter int TAG_W       = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [TAG_W-1:0]       alloc_tag,
  input  logic                   alloc_bar,
  input  logic [OTHER_DEPTH-1:0] other_live,
  input  logic [OTHER_DEPTH-1:0] other_free,
  input  logic                   exec_en,
  input  logic [TAG_W-1:0]       exec_tag,
  input  logic [TAG_W-1:0]       query_tag,
  output logic [DEPTH-1:0]       live_o,
  output logic [DEPTH-1:0]       free_o,
  output logic [DEPTH-1:0]       bar_vec_o,
  output logic                   slot_avail_o,
  output logic [CNT_W-1:0]       count_o,
  output logic                   q_hit_o,
  output logic                   q_bar_o,
  output logic [DEPTH-1:0]       q_own_older_o,
  output logic [OTHER_DEPTH-1:0] q_other_older_o
);

  logic [DEPTH-1:0]       valid_q;
  logic [DEPTH-1:0]       bar_q;
  logic [TAG_W-1:0]       tag_q       [DEPTH];
  logic [DEPTH-1:0]       own_older_q [DEPTH];
  logic [OTHER_DEPTH-1:0] oth_older_q [DEPTH];
  logic [IDX_W-1:0]       alloc_idx;

  // Release match per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_free
    assign free_o[g] = valid_q[g] && exec_en && (tag_q[g] == exec_tag);
  end

  assign live_o       = valid_q & ~free_o;
  assign bar_vec_o    = valid_q & bar_q;
  assign slot_avail_o = ~&valid_q;
  assign count_o      = CNT_W'($countones(valid_q));

  // Lowest free slot
  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) alloc_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      bar_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]       <= '0;
        own_older_q[i] <= '0;
        oth_older_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_o[i]) valid_q[i] <= 1'b0;
        if (alloc_en && (alloc_idx == IDX_W'(i))) begin
          valid_q[i]     <= 1'b1;
          tag_q[i]       <= alloc_tag;
          bar_q[i]       <= alloc_bar;
          own_older_q[i] <= live_o;
          oth_older_q[i] <= other_live;
        end else begin
          own_older_q[i] <= own_older_q[i] & ~free_o;
          oth_older_q[i] <= oth_older_q[i] & ~other_free;
        end
      end
    end
  end

  // Query lookup (tags are unique among held entries)
  always_comb begin
    q_hit_o         = 1'b0;
    q_bar_o         = 1'b0;
    q_own_older_o   = '0;
    q_other_older_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && (tag_q[i] == query_tag)) begin
        q_hit_o         = 1'b1;
        q_bar_o         = q_bar_o | bar_q[i];
        q_own_older_o   = q_own_older_o | own_older_q[i];
        q_other_older_o = q_other_older_o | oth_older_q[i];
      end
    end
  end

  // R9: allocation only ever lands in a free slot
  p_alloc_into_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> slot_avail_o);

  // R10: a released slot is empty on the next cycle
  p_freed_slot_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> ((valid_q & $past(free_o)) == '0));

  // R10: age links only ever point at held entries
  p_older_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit_o |-> ((q_own_older_o & ~valid_q) == '0));

endmodule

// File: rtl/lsq_issue_eval.sv
module lsq_issue_eval
  import lsq_pkg::*;
#(
  parameter int LQ_D = 4,
  parameter int SQ_D = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            no_alias,
  input  logic            lq_hit,
  input  logic            lq_bar,
  input  logic [LQ_D-1:0] lq_own_older,
  input  logic [SQ_D-1:0] lq_other_older,
  input  logic [LQ_D-1:0] lq_bar_vec,
  input  logic            sq_hit,
  input  logic            sq_bar,
  input  logic [SQ_D-1:0] sq_own_older,
  input  logic [LQ_D-1:0] sq_other_older,
  input  logic [SQ_D-1:0] sq_bar_vec,
  output logic            ready_o
);

  logic older_ld_bar;
  logic older_st_bar;
  logic ld_ok;
  logic st_ok;

  assign older_ld_bar = |(lq_own_older & lq_bar_vec);
  assign older_st_bar = |(sq_own_older & sq_bar_vec);
  assign ld_ok = load_side_ok(older_ld_bar, |lq_other_older, |lq_own_older,
                              lq_bar, no_alias);
  assign st_ok = store_side_ok(|sq_own_older, |sq_other_older, older_st_bar, sq_bar);
  assign ready_o = (lq_hit || sq_hit) && (!lq_hit || ld_ok) && (!sq_hit || st_ok);

  // R2: an older store holds a store back
  p_store_after_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_hit && |sq_own_older) |-> !ready_o);

  // R3: an older load holds a store back in either alias mode
  p_store_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_hit && |sq_other_older) |-> !ready_o);

  // R5: alias mode keeps loads behind older stores
  p_load_after_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_hit && !no_alias && |lq_other_older) |-> !ready_o);

  // R6: an older load barrier holds a load back
  p_load_after_barrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_hit && older_ld_bar) |-> !ready_o);

endmodule

// File: rtl/lsq_order_checker.sv
module lsq_order_checker
  import lsq_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int LQ_SIZE  = 3,
  parameter int SQ_SIZE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             no_alias_i,
  input  logic             alloc_valid_i,
  output logic             alloc_ready_o,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic             alloc_ld_i,
  input  logic             alloc_st_i,
  input  logic             alloc_se_i,
  input  logic [TAG_W-1:0] query_tag_i,
  output logic             query_ready_o,
  input  logic             exec_valid_i,
  input  logic [TAG_W-1:0] exec_tag_i,
  output logic             lq_full_o,
  output logic             lq_empty_o,
  output logic             sq_full_o,
  output logic             sq_empty_o
);

  localparam int LQ_CW = $clog2(LQ_DEPTH + 1);
  localparam int SQ_CW = $clog2(SQ_DEPTH + 1);

  logic [LQ_DEPTH-1:0] lq_live, lq_free, lq_bar_vec, lq_q_own;
  logic [SQ_DEPTH-1:0] sq_live, sq_free, sq_bar_vec, sq_q_own;
  logic [SQ_DEPTH-1:0] lq_q_oth;
  logic [LQ_DEPTH-1:0] sq_q_oth;
  logic [LQ_CW-1:0]    lq_cnt;
  logic [SQ_CW-1:0]    sq_cnt;
  logic lq_avail, sq_avail, lq_hit, sq_hit, lq_q_bar, sq_q_bar;
  logic lq_block, sq_block, alloc_fire;

  assign lq_block      = queue_blocked(int'(lq_cnt), LQ_SIZE, lq_avail);
  assign sq_block      = queue_blocked(int'(sq_cnt), SQ_SIZE, sq_avail);
  assign alloc_ready_o = !(alloc_ld_i && lq_block) && !(alloc_st_i && sq_block);
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;

  assign lq_full_o  = (LQ_SIZE != 0) && (int'(lq_cnt) == LQ_SIZE);
  assign sq_full_o  = (SQ_SIZE != 0) && (int'(sq_cnt) == SQ_SIZE);
  assign lq_empty_o = (lq_cnt == '0);
  assign sq_empty_o = (sq_cnt == '0);

  lsq_queue #(.DEPTH(LQ_DEPTH), .OTHER_DEPTH(SQ_DEPTH), .TAG_W(TAG_W)) u_lq (
    .clk, .rst_n,
    .alloc_en        (alloc_fire && alloc_ld_i),
    .alloc_tag       (alloc_tag_i),
    .alloc_bar       (alloc_se_i),
    .other_live      (sq_live),
    .other_free      (sq_free),
    .exec_en         (exec_valid_i),
    .exec_tag        (exec_tag_i),
    .query_tag       (query_tag_i),
    .live_o          (lq_live),
    .free_o          (lq_free),
    .bar_vec_o       (lq_bar_vec),
    .slot_avail_o    (lq_avail),
    .count_o         (lq_cnt),
    .q_hit_o         (lq_hit),
    .q_bar_o         (lq_q_bar),
    .q_own_older_o   (lq_q_own),
    .q_other_older_o (lq_q_oth)
  );

  lsq_queue #(.DEPTH(SQ_DEPTH), .OTHER_DEPTH(LQ_DEPTH), .TAG_W(TAG_W)) u_sq (
    .clk, .rst_n,
    .alloc_en        (alloc_fire && alloc_st_i),
    .alloc_tag       (alloc_tag_i),
    .alloc_bar       (alloc_se_i),
    .other_live      (lq_live),
    .other_free      (lq_free),
    .exec_en         (exec_valid_i),
    .exec_tag        (exec_tag_i),
    .query_tag       (query_tag_i),
    .live_o          (sq_live),
    .free_o          (sq_free),
    .bar_vec_o       (sq_bar_vec),
    .slot_avail_o    (sq_avail),
    .count_o         (sq_cnt),
    .q_hit_o         (sq_hit),
    .q_bar_o         (sq_q_bar),
    .q_own_older_o   (sq_q_own),
    .q_other_older_o (sq_q_oth)
  );

  lsq_issue_eval #(.LQ_D(LQ_DEPTH), .SQ_D(SQ_DEPTH)) u_eval (
    .clk, .rst_n,
    .no_alias       (no_alias_i),
    .lq_hit         (lq_hit),
    .lq_bar         (lq_q_bar),
    .lq_own_older   (lq_q_own),
    .lq_other_older (lq_q_oth),
    .lq_bar_vec     (lq_bar_vec),
    .sq_hit         (sq_hit),
    .sq_bar         (sq_q_bar),
    .sq_own_older   (sq_q_own),
    .sq_other_older (sq_q_oth),
    .sq_bar_vec     (sq_bar_vec),
    .ready_o        (query_ready_o)
  );

  // R8: load occupancy never passes its configured size
  p_lq_within_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (LQ_SIZE == 0) || (int'(lq_cnt) <= LQ_SIZE));

  // R9: a refused offer leaves occupancy unchanged when nothing executes
  p_refused_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid_i && !alloc_ready_o && !exec_valid_i) |=> ($stable(lq_cnt) && $stable(sq_cnt)));

  // R1: an accepted read-only offer grows only the load queue
  p_load_takes_lq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && alloc_ld_i && !alloc_st_i && !exec_valid_i) |=>
      ((lq_cnt == $past(lq_cnt) + 1'b1) && $stable(sq_cnt)));

endmodule

// File: tb/tb_lsq_order_checker.sv
module tb_lsq_order_checker;

  localparam int TAG_W  = 4;
  localparam int LQ_LIM = 3;   // configured load size
  localparam int SQ_LIM = 4;   // store size 0 -> physical depth 4

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic no_alias = 1'b0;
  logic a_valid = 1'b0, a_ld = 1'b0, a_st = 1'b0, a_se = 1'b0;
  logic [TAG_W-1:0] a_tag = '0, q_tag = '0, e_tag = '0;
  logic e_valid = 1'b0;
  logic a_ready, q_ready, lq_full, lq_empty, sq_full, sq_empty;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lsq_order_checker #(.TAG_W(TAG_W), .LQ_DEPTH(4), .SQ_DEPTH(4),
                      .LQ_SIZE(3), .SQ_SIZE(0)) dut (
    .clk, .rst_n,
    .no_alias_i(no_alias), .alloc_valid_i(a_valid), .alloc_ready_o(a_ready),
    .alloc_tag_i(a_tag), .alloc_ld_i(a_ld), .alloc_st_i(a_st), .alloc_se_i(a_se),
    .query_tag_i(q_tag), .query_ready_o(q_ready),
    .exec_valid_i(e_valid), .exec_tag_i(e_tag),
    .lq_full_o(lq_full), .lq_empty_o(lq_empty),
    .sq_full_o(sq_full), .sq_empty_o(sq_empty)
  );

  // Reference model: program-ordered list of held operations
  typedef struct packed { logic [TAG_W-1:0] tag; logic ld; logic st; logic se; } op_t;
  op_t prog[$];

  function automatic int m_find(input logic [TAG_W-1:0] t);
    for (int k = 0; k < prog.size(); k++) if (prog[k].tag == t) return k;
    return -1;
  endfunction

  function automatic int m_lq();
    int c = 0;
    foreach (prog[k]) if (prog[k].ld) c++;
    return c;
  endfunction

  function automatic int m_sq();
    int c = 0;
    foreach (prog[k]) if (prog[k].st) c++;
    return c;
  endfunction

  function automatic logic m_ready(input logic [TAG_W-1:0] t, input logic na);
    int k = m_find(t);
    logic ok = 1'b1;
    if (k < 0) return 1'b0;
    for (int p = 0; p < k; p++) begin
      if (prog[k].ld) begin
        if (prog[p].ld && prog[p].se) ok = 1'b0;
        if (prog[p].st && !na) ok = 1'b0;
        if (prog[k].se && prog[p].ld) ok = 1'b0;
      end
      if (prog[k].st && (prog[p].st || prog[p].ld)) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic m_accept(input logic ld, input logic st);
    return !(ld && m_lq() >= LQ_LIM) && !(st && m_sq() >= SQ_LIM);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // One clock: drive, compare against model, clock, update model
  task automatic step(input logic av, input logic [TAG_W-1:0] at, input logic ld,
                      input logic st, input logic se, input logic ev,
                      input logic [TAG_W-1:0] et);
    logic acc;
    a_valid = av; a_tag = at; a_ld = ld; a_st = st; a_se = se;
    e_valid = ev; e_tag = et;
    #1;
    acc = m_accept(ld, st);
    chk("R9",  "alloc_ready vs model", a_ready, acc);
    chk("R11", "query_ready vs model", q_ready, m_ready(q_tag, no_alias));
    chk("R8",  "lq_full vs model", lq_full, m_lq() == LQ_LIM);
    chk("R8",  "sq_full vs model", sq_full, 1'b0);
    chk("R1",  "lq_empty vs model", lq_empty, m_lq() == 0);
    chk("R1",  "sq_empty vs model", sq_empty, m_sq() == 0);
    @(posedge clk);
    if (ev) for (int k = prog.size() - 1; k >= 0; k--) if (prog[k].tag == et) prog.delete(k);
    if (av && acc && (ld || st)) prog.push_back('{tag: at, ld: ld, st: st, se: se});
    @(negedge clk);
    a_valid = 1'b0; e_valid = 1'b0;
  endtask

  task automatic alloc(input logic [TAG_W-1:0] t, input logic ld, input logic st, input logic se);
    step(1'b1, t, ld, st, se, 1'b0, '0);
  endtask

  task automatic exec(input logic [TAG_W-1:0] t);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, t);
  endtask

  task automatic peek(input string req, input logic [TAG_W-1:0] t, input logic na, input logic exp);
    q_tag = t; no_alias = na;
    #1;
    chk(req, $sformatf("query tag %0d no_alias %0b", t, na), q_ready, exp);
    chk(req, "query vs model", q_ready, m_ready(t, na));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R13: reset state
    chk("R13", "lq_empty", lq_empty, 1'b1);
    chk("R13", "sq_empty", sq_empty, 1'b1);
    chk("R13", "lq_full", lq_full, 1'b0);
    chk("R13", "sq_full", sq_full, 1'b0);
    a_ld = 1'b1; a_st = 1'b1; #1;
    chk("R13", "alloc_ready", a_ready, 1'b1);
    a_ld = 1'b0; a_st = 1'b0;
    @(negedge clk);

    // R1: slot usage by attribute
    alloc(4'd9, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R1", "neither: lq_empty", lq_empty, 1'b1);
    chk("R1", "neither: sq_empty", sq_empty, 1'b1);
    peek("R1", 4'd9, 1'b0, 1'b0);
    alloc(4'd10, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R1", "both: lq_empty", lq_empty, 1'b0);
    chk("R1", "both: sq_empty", sq_empty, 1'b0);
    exec(4'd10);
    #1;
    chk("R10", "release both: lq_empty", lq_empty, 1'b1);
    chk("R10", "release both: sq_empty", sq_empty, 1'b1);

    // R2 R3 R5: load/store interplay
    alloc(4'd1, 1'b1, 1'b0, 1'b0);
    alloc(4'd2, 1'b0, 1'b1, 1'b0);
    alloc(4'd3, 1'b1, 1'b0, 1'b0);
    alloc(4'd4, 1'b0, 1'b1, 1'b0);
    peek("R3", 4'd2, 1'b0, 1'b0);
    peek("R3", 4'd2, 1'b1, 1'b0);
    peek("R5", 4'd3, 1'b0, 1'b0);
    peek("R5", 4'd3, 1'b1, 1'b1);
    peek("R2", 4'd4, 1'b1, 1'b0);
    exec(4'd1);
    peek("R3", 4'd2, 1'b0, 1'b1);
    peek("R2", 4'd4, 1'b0, 1'b0);
    exec(4'd3);
    peek("R2", 4'd4, 1'b0, 1'b0);
    exec(4'd2);
    peek("R2", 4'd4, 1'b0, 1'b1);
    exec(4'd4);

    // R4: load passes load
    alloc(4'd1, 1'b1, 1'b0, 1'b0);
    alloc(4'd5, 1'b1, 1'b0, 1'b0);
    peek("R4", 4'd5, 1'b0, 1'b1);
    peek("R4", 4'd1, 1'b0, 1'b1);
    exec(4'd5);
    exec(4'd1);

    // R6: load barrier
    alloc(4'd1, 1'b1, 1'b0, 1'b0);
    alloc(4'd2, 1'b1, 1'b0, 1'b1);
    alloc(4'd3, 1'b1, 1'b0, 1'b0);
    peek("R6", 4'd2, 1'b0, 1'b0);
    peek("R6", 4'd3, 1'b0, 1'b0);
    exec(4'd1);
    peek("R6", 4'd2, 1'b0, 1'b1);
    peek("R6", 4'd3, 1'b0, 1'b0);
    exec(4'd2);
    peek("R6", 4'd3, 1'b0, 1'b1);
    exec(4'd3);

    // R7: store barrier
    alloc(4'd1, 1'b0, 1'b1, 1'b0);
    alloc(4'd2, 1'b0, 1'b1, 1'b1);
    alloc(4'd3, 1'b0, 1'b1, 1'b0);
    peek("R7", 4'd2, 1'b0, 1'b0);
    peek("R7", 4'd3, 1'b0, 1'b0);
    exec(4'd1);
    peek("R7", 4'd2, 1'b0, 1'b1);
    peek("R7", 4'd3, 1'b0, 1'b0);
    exec(4'd2);
    peek("R7", 4'd3, 1'b0, 1'b1);
    exec(4'd3);

    // R7: full barrier between both queues
    alloc(4'd4, 1'b1, 1'b0, 1'b0);
    alloc(4'd5, 1'b1, 1'b1, 1'b1);
    alloc(4'd6, 1'b1, 1'b0, 1'b0);
    alloc(4'd7, 1'b0, 1'b1, 1'b0);
    peek("R7", 4'd5, 1'b1, 1'b0);
    peek("R7", 4'd6, 1'b1, 1'b0);
    peek("R7", 4'd7, 1'b1, 1'b0);
    exec(4'd4);
    peek("R7", 4'd5, 1'b1, 1'b1);
    peek("R7", 4'd6, 1'b1, 1'b0);
    exec(4'd5);
    peek("R7", 4'd6, 1'b1, 1'b1);
    peek("R3", 4'd7, 1'b1, 1'b0);
    exec(4'd6);
    peek("R3", 4'd7, 1'b1, 1'b1);
    exec(4'd7);

    // R8 R9: capacity
    alloc(4'd1, 1'b1, 1'b0, 1'b0);
    alloc(4'd2, 1'b1, 1'b0, 1'b0);
    alloc(4'd3, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R8", "lq_full at size", lq_full, 1'b1);
    a_ld = 1'b1; #1;
    chk("R9", "load refused when lq full", a_ready, 1'b0);
    a_ld = 1'b0;
    @(negedge clk);
    alloc(4'd4, 1'b1, 1'b0, 1'b0);
    peek("R9", 4'd4, 1'b0, 1'b0);
    alloc(4'd5, 1'b0, 1'b1, 1'b0);
    #1;
    chk("R9", "store accepted with lq full", sq_empty, 1'b0);
    alloc(4'd6, 1'b0, 1'b1, 1'b0);
    alloc(4'd7, 1'b0, 1'b1, 1'b0);
    alloc(4'd8, 1'b0, 1'b1, 1'b0);
    #1;
    chk("R8", "sq_full with size 0 and 4 held", sq_full, 1'b0);
    a_st = 1'b1; #1;
    chk("R9", "store refused when sq slots used", a_ready, 1'b0);
    a_st = 1'b0;
    @(negedge clk);
    alloc(4'd11, 1'b0, 1'b1, 1'b0);
    alloc(4'd12, 1'b1, 1'b1, 1'b0);
    peek("R9", 4'd12, 1'b0, 1'b0);

    // R10: unknown tag ignored
    exec(4'd0);
    #1;
    chk("R10", "unknown tag keeps lq_full", lq_full, 1'b1);
    exec(4'd1);
    #1;
    chk("R10", "release clears lq_full", lq_full, 1'b0);

    // R12: allocate and execute on one edge
    step(1'b1, 4'd13, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2);
    #1;
    chk("R12", "lq_full after swap", lq_full, 1'b0);
    peek("R12", 4'd13, 1'b1, 1'b1);
    peek("R12", 4'd2, 1'b1, 1'b0);
    alloc(4'd15, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R12", "lq_full after one more", lq_full, 1'b1);

    // drain
    exec(4'd8); exec(4'd3); exec(4'd13); exec(4'd15);
    exec(4'd5); exec(4'd7); exec(4'd6);
    #1;
    chk("R10", "drained lq_empty", lq_empty, 1'b1);
    chk("R10", "drained sq_empty", sq_empty, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule